// File: doc/BRIEF.md
# Count Clock Enable Generator

This block produces the count-enable strobe that advances one timer channel. Everything runs on one system clock. The strobe comes from one of two sources. The first is a free-running 15-bit prescaler, which divides the system clock by any power of two from 1 to 32768. The second is an external timer input pin. That pin passes through a two-flop synchronizer and an edge detector, which can be set to react to rising edges, falling edges, both edges, or none.

Every divided clock appears as a pulse one system clock wide, never as a square wave. At a ratio of 1 the enable is held high, so the counter can step on every clock. A 16-bit up/down counter is driven by the strobe. It lets the timing from enable to count be observed at the ports. The counter changes one system clock after the count clock's rising edge.

Top module: `tmr_cnt_clk_gen`

## Requirements
- R1: `src_sel_i`=0 routes the prescaler tick to `count_en_o`. `src_sel_i`=1 routes the pin edge strobe, and the prescaler then has no effect on `count_en_o`.
- R2: With `src_sel_i`=0 and `ratio_i`=k (4 bits, k=1..15), `count_en_o` is high exactly in those cycles where the number of rising clock edges since reset release is a multiple of 2^k.
- R3: For any ratio k>=1, each prescaler strobe lasts exactly one clock cycle.
- R4: With `src_sel_i`=0 and `ratio_i`=0, `count_en_o` stays high in every cycle.
- R5: `count_o` takes its new value on the first rising clock edge after a cycle in which `count_en_o` and `cnt_en_i` are both high. The change is visible in the cycle after the strobe.
- R6: `dir_up_i`=1 adds one per qualified strobe, and `dir_up_i`=0 subtracts one.
- R7: While `cnt_en_i`=0, `count_o` holds its value whatever the strobe does.
- R8: `count_o` wraps modulo 2^16: 0xFFFF+1 gives 0, and 0-1 gives 0xFFFF.
- R9: A change of `ratio_i` takes effect at the new ratio's next tap boundary of the free-running prescaler. No extra pulse is generated by the change.
- R10: A pin change made between clock edges gives a strobe that is high in the cycle after the second rising edge, and low in the cycles before and after it.
- R11: `edge_mode_i` encodes 0 = rising, 1 = falling, 2 = both, 3 = none. Each qualifying edge gives exactly one strobe, and a non-qualifying edge gives none.
- R12: Asynchronous active-low reset clears the prescaler, the synchronizer flops and `count_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | 0 = prescaler tick, 1 = pin edge |
| ratio_i | input | 4 | Divide ratio exponent k, divide by 2^k |
| edge_mode_i | input | 2 | Pin edge selection (0 rise, 1 fall, 2 both, 3 none) |
| pin_i | input | 1 | Asynchronous external timer input |
| cnt_en_i | input | 1 | Counter gate |
| dir_up_i | input | 1 | 1 = count up, 0 = count down |
| count_en_o | output | 1 | Count-enable strobe |
| count_o | output | 16 | Up/down counter value |

## Verification
The prescaler strobe is combinational on the prescaler state. It is therefore due in the same cycle in which the number of edges since reset is a multiple of 2^k. The bench keeps its own edge counter from reset release and compares every cycle.

Counter results are due one edge after the strobe. A predictor pushes the expected value into a queue at each sample, and the monitor pops and compares it one cycle later.

Pin strobes are due two edges after the pin changes. The directed task samples the strobe after one, two and three edges. All samples are taken half a cycle or one time unit away from the active edge.

// File: rtl/tcg_pkg.sv
`timescale 1ns/1ps
package tcg_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/tcg_prescaler.sv
`timescale 1ns/1ps
module tcg_prescaler #(
  parameter int PRE_W = 15,
  parameter int SEL_W = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ratio_i,
  output logic             tick_o
);
  localparam int TAPS = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [TAPS-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  // tap k fires when the low k bits roll over to zero; tap 0 is constant high
  assign tap[0] = 1'b1;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap[k] = ~|pre_q[k-1:0];
  end

  assign tick_o = tap[ratio_i];
endmodule

// File: rtl/tcg_pin_edge.sv
`timescale 1ns/1ps
module tcg_pin_edge
  import tcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  edge_mode_e mode_i,
  output logic       edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] &  prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcg_updown_cnt.sv
`timescale 1ns/1ps
module tcg_updown_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             gate_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else if (stb_i && gate_i)
      count_o <= up_i ? count_o + CNT_W'(1) : count_o - CNT_W'(1);
  end
endmodule

// File: rtl/tmr_cnt_clk_gen.sv
`timescale 1ns/1ps
module tmr_cnt_clk_gen
  import tcg_pkg::*;
#(
  parameter int PRE_W       = 15,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_sel_i,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             pin_i,
  input  logic             cnt_en_i,
  input  logic             dir_up_i,
  output logic             count_en_o,
  output logic [CNT_W-1:0] count_o
);
  logic pre_tick, pin_tick;

  tcg_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .tick_o  (pre_tick)
  );

  tcg_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mode_i (edge_mode_e'(edge_mode_i)),
    .edge_o (pin_tick)
  );

  assign count_en_o = src_sel_i ? pin_tick : pre_tick;

  tcg_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (count_en_o),
    .gate_i  (cnt_en_i),
    .up_i    (dir_up_i),
    .count_o (count_o)
  );
endmodule

// File: rtl/tcg_chk.sv
`timescale 1ns/1ps
module tcg_chk #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             src_sel_i,
  input logic [SEL_W-1:0] ratio_i,
  input logic [1:0]       edge_mode_i,
  input logic             cnt_en_i,
  input logic             dir_up_i,
  input logic             count_en_o,
  input logic [CNT_W-1:0] count_o
);
  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && !src_sel_i && ratio_i != '0) |=> !(count_en_o && !src_sel_i && ratio_i != '0));

  // R4
  ratio_one_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel_i && ratio_i == '0) |-> count_en_o);

  // R6
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && cnt_en_i && dir_up_i) |=> count_o == $past(count_o) + CNT_W'(1));

  // R6
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_o && cnt_en_i && !dir_up_i) |=> count_o == $past(count_o) - CNT_W'(1));

  // R7
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(count_en_o && cnt_en_i) |=> $stable(count_o));

  // R11
  edge_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i && edge_mode_i == 2'd3) |-> !count_en_o);
endmodule

bind tmr_cnt_clk_gen tcg_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_sel_i   (src_sel_i),
  .ratio_i     (ratio_i),
  .edge_mode_i (edge_mode_i),
  .cnt_en_i    (cnt_en_i),
  .dir_up_i    (dir_up_i),
  .count_en_o  (count_en_o),
  .count_o     (count_o)
);

// File: tb/tmr_cnt_clk_gen_tb.sv
`timescale 1ns/1ps
module tmr_cnt_clk_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_sel_i = 1'b0;
  logic [3:0]  ratio_i = 4'd0;
  logic [1:0]  edge_mode_i = 2'd0;
  logic        pin_i = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        dir_up_i = 1'b1;
  logic        count_en_o;
  logic [15:0] count_o;

  int          errors = 0;
  int          checks = 0;
  int          cyc;
  int          stb_seen = 0;
  logic        prev_stb = 1'b0;
  logic        exp_stb;
  logic [15:0] model = '0;
  logic [15:0] popped;
  logic [15:0] exp_q[$];
  int          mask;

  tmr_cnt_clk_gen u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_sel_i   (src_sel_i),
    .ratio_i     (ratio_i),
    .edge_mode_i (edge_mode_i),
    .pin_i       (pin_i),
    .cnt_en_i    (cnt_en_i),
    .dir_up_i    (dir_up_i),
    .count_en_o  (count_en_o),
    .count_o     (count_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // rising edges since reset release
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // monitor + predictor at the falling edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      exp_q.delete();
      model = '0;
      prev_stb = 1'b0;
    end else begin
      if (exp_q.size() > 0) begin
        popped = exp_q.pop_front();
        chk(count_o == popped, "R5 count one cycle after strobe", count_o, popped);
      end
      if (!src_sel_i) begin
        mask = (1 << ratio_i) - 1;
        exp_stb = ((cyc & mask) == 0);
        chk(count_en_o == exp_stb, (ratio_i == 0) ? "R4 ratio one high" : "R2 R9 tap phase",
            count_en_o, exp_stb);
        if (ratio_i != 0 && count_en_o)
          chk(!prev_stb, "R3 single cycle strobe", prev_stb, 0);
      end
      if (count_en_o) stb_seen++;
      if (count_en_o && cnt_en_i) model = dir_up_i ? model + 16'd1 : model - 16'd1;
      exp_q.push_back(model);
      prev_stb = count_en_o && !src_sel_i;
    end
  end

  task automatic pin_edge(input logic lvl, input logic exp, input string req);
    pin_i = lvl;
    step(1);
    chk(count_en_o == 1'b0, req, count_en_o, 0);
    step(1);
    chk(count_en_o == exp, req, count_en_o, exp);
    step(1);
    chk(count_en_o == 1'b0, req, count_en_o, 0);
    step(2);
  endtask

  initial begin
    int n0;
    logic [15:0] c0;
    step(3);
    chk(count_o == 16'd0, "R12 reset count", count_o, 0);
    rst_ni = 1'b1;
    step(2);
    chk(count_o == 16'd0, "R12 count after release gate off", count_o, 0);

    cnt_en_i = 1'b1;
    c0 = count_o;
    step(10);
    chk(count_o == c0 + 16'd10, "R6 up by ten", count_o, c0 + 16'd10);
    dir_up_i = 1'b0;
    step(13);
    chk(count_o == 16'hFFFD, "R8 wrap down", count_o, 16'hFFFD);
    dir_up_i = 1'b1;
    step(3);
    chk(count_o == 16'h0000, "R8 wrap up", count_o, 0);
    cnt_en_i = 1'b0;
    step(7);
    chk(count_o == 16'h0000, "R7 hold while gated", count_o, 0);
    cnt_en_i = 1'b1;

    for (int k = 1; k < 8; k += 3) begin
      ratio_i = 4'(k);
      n0 = stb_seen;
      c0 = count_o;
      step(4 << k);
      chk(stb_seen - n0 == 4, "R2 pulses per window", stb_seen - n0, 4);
      chk(16'(count_o - c0) == 16'd4, "R5 counts per window", 16'(count_o - c0), 4);
    end

    ratio_i = 4'd5;
    step(13);
    ratio_i = 4'd2;
    n0 = stb_seen;
    step(8);
    chk(stb_seen - n0 == 2, "R9 new ratio pulses", stb_seen - n0, 2);

    ratio_i = 4'd15;
    n0 = stb_seen;
    step(32768);
    chk(stb_seen - n0 == 1, "R2 max ratio window", stb_seen - n0, 1);

    ratio_i = 4'd0;
    src_sel_i = 1'b1;
    edge_mode_i = 2'd0;
    n0 = stb_seen;
    step(6);
    chk(stb_seen - n0 == 0, "R1 pin source ignores prescaler", stb_seen - n0, 0);

    pin_edge(1'b1, 1'b1, "R10 rise strobe timing");
    pin_edge(1'b0, 1'b0, "R11 rise mode ignores fall");
    edge_mode_i = 2'd1;
    pin_edge(1'b1, 1'b0, "R11 fall mode ignores rise");
    pin_edge(1'b0, 1'b1, "R11 fall mode strobe");
    edge_mode_i = 2'd2;
    pin_edge(1'b1, 1'b1, "R11 both mode rise");
    pin_edge(1'b0, 1'b1, "R11 both mode fall");
    edge_mode_i = 2'd3;
    n0 = stb_seen;
    pin_edge(1'b1, 1'b0, "R11 none mode rise");
    pin_edge(1'b0, 1'b0, "R11 none mode fall");
    chk(stb_seen - n0 == 0, "R11 none mode count", stb_seen - n0, 0);

    src_sel_i = 1'b0;
    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule